// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash bus. Once software has issued a program or erase command to the flash, it starts the poller. The poller then decides whether the embedded operation has finished or failed by watching a status bit that flips on every read for as long as the operation runs. It issues read cycles at a chosen address in pairs. It compares the toggle bit (bit 6 of the read word) across the two reads of a pair. When the bit keeps moving, it also looks at the time-limit bit (bit 5).

When the time-limit bit is seen high, the poller does not declare failure at once. It runs one more read pair first, because the operation may have finished in the same moment the limit flag rose. Only if the bit is still moving in that extra pair does the poller report failure. In that case it also writes a fixed command word so that the flash returns to normal array reads. A pass-count watchdog stops a poll that never settles. An abort input lets software drop the poll and start it again later. A restarted poll always begins from a fresh read pair and keeps nothing from the earlier attempt.

Top module: `tgp_poll_ctrl`

## Requirements
- R1: After reset, busy, rd_stb, wr_stb, done_pulse, fail_pulse, done_flag and fail_flag are all 0.
- R2: A start seen while idle raises busy and drives rd_stb in the next cycle, with bus_addr equal to poll_addr. Each read strobe lasts one cycle. The word is captured at the end of the RD_LAT-th cycle after the strobe. Reads come in pairs, one strobe every RD_LAT+2 cycles, so a full pass takes 2*(RD_LAT+2) cycles.
- R3: If bit 6 has the same value in both reads of a pass, done_pulse is high for exactly one cycle right after the pass. In that same cycle busy falls and done_flag is set, and no write is made.
- R4: If bit 6 differs between the two reads and bit 5 of the second read is 0, a new pass starts in the cycle right after the pass.
- R5: If bit 6 differs and bit 5 of the second read is 1, one further pass is run. If bit 6 is stable in that further pass, the result is success as in R3.
- R6: If bit 6 still differs in the pass that follows a bit-5 sighting, wr_stb is high for one cycle with bus_addr = RST_ADDR and bus_wdata = RST_DATA (default 0xF0). In the next cycle fail_pulse is high for one cycle, fail_flag is set and busy falls.
- R7: If MAX_PASSES consecutive passes all show bit 6 moving, the poll ends with the reset write and failure, as in R6.
- R8: An abort during a poll, outside the reset write, drops busy in the next cycle with no pulse and no write. The next start begins with a fresh pass that keeps no earlier bit-5 sighting and no earlier pass count.
- R9: An accepted start clears done_flag and fail_flag. A start that arrives while busy is ignored and does not change the read sequence.
- R10: rd_stb and wr_stb are never high in the same cycle, and done_pulse and fail_pulse are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a poll (taken only while idle) |
| abort | input | 1 | Leave the current poll |
| poll_addr | input | AW | Address used for the status reads |
| rd_stb | output | 1 | One-cycle read strobe |
| wr_stb | output | 1 | One-cycle write strobe for the reset command |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data (the reset command word) |
| bus_rdata | input | DW | Read data, valid RD_LAT cycles after the strobe |
| busy | output | 1 | Poll in progress |
| done_pulse | output | 1 | One-cycle success indication |
| fail_pulse | output | 1 | One-cycle failure indication |
| done_flag | output | 1 | Sticky success, cleared by start |
| fail_flag | output | 1 | Sticky failure, cleared by start |

## Verification
Assertions check the following on every cycle:
- read strobes last one cycle, never overlap an outstanding read, and never coincide with a write;
- the two pulses never occur together;
- every failure pulse comes right after the reset write;
- an abort always returns the poller to idle quietly.

Some behaviour can only be shown by the bench scenarios, which compare full cycle traces against a model that walks the scripted status words. These cover:
- the verdict chosen from a given status sequence;
- the extra confirming pass after a bit-5 sighting;
- the watchdog pass count;
- the proof that a restarted poll carries no state over from an aborted one.

// File: rtl/tgp_pkg.sv
package tgp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_RSTW
  } tgp_state_t;

  typedef enum logic [1:0] {
    EV_DONE,
    EV_FAIL,
    EV_AGAIN,
    EV_RECHK
  } tgp_verdict_t;

  // a status bit has moved between the two reads of a pass
  function automatic logic bit_moved(input logic first, input logic second);
    return first ^ second;
  endfunction

  // outcome of a completed read pair
  function automatic tgp_verdict_t judge(input logic moved, input logic rechk,
                                         input logic limit_flag, input logic limit_hit);
    if (!moved) return EV_DONE;
    if (rechk || limit_hit) return EV_FAIL;
    if (limit_flag) return EV_RECHK;
    return EV_AGAIN;
  endfunction

endpackage

// File: rtl/tgp_rd_engine.sv
module tgp_rd_engine #(
  parameter int DW      = 8,
  parameter int RD_LAT  = 2,
  parameter int TGL_BIT = 6,
  parameter int TMO_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          kill,
  input  logic [DW-1:0] bus_rdata,
  output logic          cap_valid,
  output logic          cap_tgl,
  output logic          cap_tmo
);
  localparam int CW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;

  logic          waiting;
  logic [CW-1:0] lat_cnt;
  logic          unused_rdata;

  assign unused_rdata = ^bus_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting   <= 1'b0;
      lat_cnt   <= '0;
      cap_valid <= 1'b0;
      cap_tgl   <= 1'b0;
      cap_tmo   <= 1'b0;
    end else begin
      cap_valid <= 1'b0;
      if (kill) begin
        waiting <= 1'b0;
      end else if (launch) begin
        waiting <= 1'b1;
        lat_cnt <= CW'(RD_LAT - 1);
      end else if (waiting) begin
        if (lat_cnt == '0) begin
          waiting   <= 1'b0;
          cap_valid <= 1'b1;
          cap_tgl   <= bus_rdata[TGL_BIT];
          cap_tmo   <= bus_rdata[TMO_BIT];
        end else begin
          lat_cnt <= lat_cnt - 1'b1;
        end
      end
    end
  end

  AST_CAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> !cap_valid); // R2
  AST_NO_OVERLAP_RD: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !waiting); // R2

endmodule

// File: rtl/tgp_pass_eval.sv
module tgp_pass_eval import tgp_pkg::*; (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         take,
  input  logic         cap_valid,
  input  logic         second,
  input  logic         q_tgl,
  input  logic         q_tmo,
  input  logic         limit_hit,
  output logic         verdict_vld,
  output tgp_verdict_t verdict,
  output logic         rechk
);
  logic tgl_first;

  assign verdict_vld = cap_valid && second;
  assign verdict     = judge(bit_moved(tgl_first, q_tgl), rechk, q_tmo, limit_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgl_first <= 1'b0;
    end else if (cap_valid && !second) begin
      tgl_first <= q_tgl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rechk <= 1'b0;
    end else if (take && verdict_vld && verdict == EV_RECHK) begin
      rechk <= 1'b1;
    end
  end

  AST_RECHK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rechk && !clr |=> rechk); // R5

endmodule

// File: rtl/tgp_pass_limit.sv
module tgp_pass_limit #(
  parameter int MAX_PASSES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic limit_hit
);
  generate
    if (MAX_PASSES == 0) begin : g_off
      logic unused_wd;
      assign unused_wd = clk ^ rst_n ^ clr ^ inc;
      assign limit_hit = 1'b0;
    end else begin : g_on
      localparam int CW = $clog2(MAX_PASSES + 1);
      logic [CW-1:0] pass_cnt;

      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          pass_cnt <= '0;
        end else if (inc) begin
          pass_cnt <= pass_cnt + 1'b1;
        end
      end

      assign limit_hit = (pass_cnt == CW'(MAX_PASSES - 1));

      AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_cnt < CW'(MAX_PASSES)); // R7
    end
  endgenerate

endmodule

// File: rtl/tgp_poll_ctrl.sv
module tgp_poll_ctrl import tgp_pkg::*; #(
  parameter int AW          = 20,
  parameter int DW          = 8,
  parameter int RD_LAT      = 2,
  parameter int MAX_PASSES  = 8,
  parameter int TGL_BIT     = 6,
  parameter int TMO_BIT     = 5,
  parameter logic [AW-1:0] RST_ADDR = '0,
  parameter logic [DW-1:0] RST_DATA = 'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [AW-1:0] poll_addr,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          done_pulse,
  output logic          fail_pulse,
  output logic          done_flag,
  output logic          fail_flag
);
  tgp_state_t   st, st_n;
  logic         idx, idx_n;
  logic         cap_valid, cap_tgl, cap_tmo;
  logic         verdict_vld, rechk, limit_hit;
  tgp_verdict_t verdict;

  // named internal events
  logic accept, poll_live, halt, pass_ok, pass_bad, pass_again;

  assign accept     = (st == ST_IDLE) && start;
  assign poll_live  = (st == ST_READ) || (st == ST_WAIT);
  assign halt       = abort && poll_live;
  assign pass_ok    = verdict_vld && !halt && verdict == EV_DONE;
  assign pass_bad   = verdict_vld && !halt && verdict == EV_FAIL;
  assign pass_again = verdict_vld && !halt &&
                      (verdict == EV_AGAIN || verdict == EV_RECHK);

  tgp_rd_engine #(
    .DW(DW), .RD_LAT(RD_LAT), .TGL_BIT(TGL_BIT), .TMO_BIT(TMO_BIT)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .launch(st == ST_READ), .kill(halt),
    .bus_rdata(bus_rdata), .cap_valid(cap_valid), .cap_tgl(cap_tgl), .cap_tmo(cap_tmo)
  );

  tgp_pass_eval u_eval (
    .clk(clk), .rst_n(rst_n), .clr(accept), .take(!halt),
    .cap_valid(cap_valid), .second(idx), .q_tgl(cap_tgl), .q_tmo(cap_tmo),
    .limit_hit(limit_hit), .verdict_vld(verdict_vld), .verdict(verdict), .rechk(rechk)
  );

  tgp_pass_limit #(.MAX_PASSES(MAX_PASSES)) u_limit (
    .clk(clk), .rst_n(rst_n), .clr(accept), .inc(pass_again), .limit_hit(limit_hit)
  );

  always_comb begin
    st_n  = st;
    idx_n = idx;
    case (st)
      ST_IDLE: if (start) begin
        st_n  = ST_READ;
        idx_n = 1'b0;
      end
      ST_READ: st_n = ST_WAIT;
      ST_WAIT: if (cap_valid) begin
        if (!idx) begin
          idx_n = 1'b1;
          st_n  = ST_READ;
        end else if (verdict == EV_DONE) begin
          st_n = ST_IDLE;
        end else if (verdict == EV_FAIL) begin
          st_n = ST_RSTW;
        end else begin
          idx_n = 1'b0;
          st_n  = ST_READ;
        end
      end
      ST_RSTW: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
    if (halt) st_n = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      idx        <= 1'b0;
      done_pulse <= 1'b0;
      fail_pulse <= 1'b0;
      done_flag  <= 1'b0;
      fail_flag  <= 1'b0;
    end else begin
      st         <= st_n;
      idx        <= idx_n;
      done_pulse <= pass_ok;
      fail_pulse <= (st == ST_RSTW);
      if (accept) begin
        done_flag <= 1'b0;
        fail_flag <= 1'b0;
      end else begin
        if (pass_ok) done_flag <= 1'b1;
        if (st == ST_RSTW) fail_flag <= 1'b1;
      end
    end
  end

  assign busy      = (st != ST_IDLE);
  assign rd_stb    = (st == ST_READ);
  assign wr_stb    = (st == ST_RSTW);
  assign bus_addr  = wr_stb ? RST_ADDR : poll_addr;
  assign bus_wdata = wr_stb ? RST_DATA : '0;

  AST_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> rd_stb); // R2
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !busy && done_flag); // R3
  AST_BAD_TO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_bad |=> wr_stb); // R6
  AST_WR_THEN_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> fail_pulse && !busy); // R6
  AST_FAIL_HAS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |-> $past(wr_stb)); // R6
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy && abort && !wr_stb |=> !busy && !done_pulse && !fail_pulse); // R8
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb)); // R10
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_pulse && fail_pulse)); // R10

endmodule

// File: tb/tgp_poll_ctrl_tb.sv
module tgp_poll_ctrl_tb;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int LAT = 2;
  localparam int MAXP = 8;
  localparam logic [AW-1:0] POLL = 20'h00AAA;
  localparam logic [AW-1:0] RADDR = 20'h00555;
  localparam logic [DW-1:0] RDATA = 8'hF0;
  localparam logic [7:0] IDLE_WORD = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic abort = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic rd_stb, wr_stb, busy, done_pulse, fail_pulse, done_flag, fail_flag;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] stat_q[$];

  always #2 clk = ~clk;

  tgp_poll_ctrl #(
    .AW(AW), .DW(DW), .RD_LAT(LAT), .MAX_PASSES(MAXP),
    .RST_ADDR(RADDR), .RST_DATA(RDATA)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .poll_addr(POLL),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done_pulse(done_pulse), .fail_pulse(fail_pulse),
    .done_flag(done_flag), .fail_flag(fail_flag)
  );

  // flash status model: each strobe returns the next scripted word
  always @(negedge clk) begin
    if (rd_stb) begin
      if (stat_q.size() > 0) bus_rdata <= stat_q.pop_front();
      else bus_rdata <= IDLE_WORD;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] word_at(input logic [7:0] lst[$], input int p);
    if (p < lst.size()) return lst[p];
    return IDLE_WORD;
  endfunction

  // reference: walk the scripted words pair by pair
  function automatic void predict(input logic [7:0] lst[$], output int ok, output int reads);
    int p = 0;
    int passes = 0;
    bit seen5 = 0;
    ok = 1;
    for (int guard = 0; guard < 100; guard++) begin
      logic [7:0] a, b;
      a = word_at(lst, p);
      b = word_at(lst, p + 1);
      p += 2;
      passes++;
      if (a[6] == b[6]) begin ok = 1; break; end
      if (seen5 || passes == MAXP) begin ok = 0; break; end
      if (b[5]) seen5 = 1;
    end
    reads = p;
  endfunction

  task automatic check(input string req, input string what, input bit good,
                       input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [7:0] lst[$], input int poke_at);
    int ok, reads, span, per, mism, first_c;
    bit eb, er, ew, ed, ef;
    predict(lst, ok, reads);
    per = LAT + 2;
    span = (reads / 2) * 2 * per + (ok ? 0 : 1);
    stat_q = lst;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    mism = 0;
    first_c = -1;
    for (int c = 0; c <= span; c++) begin
      start = (c == poke_at);
      eb = (c < span);
      er = (c < reads * per) && (c % per == 0);
      ew = (ok == 0) && (c == span - 1);
      ed = (ok == 1) && (c == span);
      ef = (ok == 0) && (c == span);
      if (busy !== eb || rd_stb !== er || wr_stb !== ew || done_pulse !== ed || fail_pulse !== ef ||
          (rd_stb && bus_addr !== POLL) ||
          (wr_stb && (bus_addr !== RADDR || bus_wdata !== RDATA))) begin
        if (first_c < 0) begin
          first_c = c;
          $display("FAIL %s trace at cycle %0d: actual b%0b r%0b w%0b d%0b f%0b addr %0h expected b%0b r%0b w%0b d%0b f%0b",
                   req, c, busy, rd_stb, wr_stb, done_pulse, fail_pulse, bus_addr, eb, er, ew, ed, ef);
        end
        mism++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    checks++;
    if (mism != 0) errors++;
    check(req, "done_flag", done_flag === ok[0], done_flag, ok);
    check(req, "fail_flag", fail_flag === !ok[0], fail_flag, !ok[0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "outputs after reset",
          {busy, rd_stb, wr_stb, done_pulse, fail_pulse, done_flag, fail_flag} === 7'b0,
          {busy, rd_stb, wr_stb, done_pulse, fail_pulse, done_flag, fail_flag}, 0);

    // R2 R3: stable on the first pair
    run("R3", '{8'h40, 8'h40}, -1);
    // R4: moving with bit 5 low, then stable
    run("R4", '{8'h40, 8'h00, 8'h40, 8'h40}, -1);
    // R5: bit 5 seen, confirming pass is stable
    run("R5", '{8'h00, 8'h60, 8'h44, 8'h44}, -1);
    // R6: bit 5 seen, still moving -> reset write and failure
    run("R6", '{8'h00, 8'h60, 8'h20, 8'h60}, -1);
    // R9: start clears the failure flag; start while busy is ignored (R2 timing kept)
    run("R9", '{8'h00, 8'h40, 8'h40, 8'h40}, 3);
    // R5 after several plain passes
    run("R5", '{8'h00, 8'h40, 8'h40, 8'h00, 8'h00, 8'h60, 8'h40, 8'h40}, -1);
    // R7: never settles
    run("R7", '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40,
                8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40}, -1);

    // R8: abort after a bit-5 sighting, during the confirming pass
    stat_q = '{8'h00, 8'h60, 8'h00, 8'h40};
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 9; c++) @(negedge clk);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    check("R8", "busy after abort", busy === 1'b0, busy, 0);
    for (int c = 0; c < 4; c++) begin
      check("R8", "quiet after abort", {done_pulse, fail_pulse, wr_stb, rd_stb} === 4'b0,
            {done_pulse, fail_pulse, wr_stb, rd_stb}, 0);
      @(negedge clk);
    end
    check("R9", "flags cleared by start", {done_flag, fail_flag} === 2'b00,
          {done_flag, fail_flag}, 0);
    // restart: a moving pass with bit 5 low must not fail (no stale sighting)
    run("R8", '{8'h40, 8'h00, 8'h40, 8'h40}, -1);
    // R10 checked every cycle by the traces above; final idle state
    check("R10", "idle strobes", {rd_stb, wr_stb} === 2'b00, {rd_stb, wr_stb}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule